// File: doc/BRIEF.md
# Page-Offset-Indexed Data Cache with Physical Tags

This block is a direct-mapped data cache of 4 KB, laid out as 1024 lines of four bytes. The line index and the byte select are both taken from the untranslated low twelve bits of the virtual address, which are exactly the page offset. The data, tag and valid arrays can therefore be read while the translation buffer is still working on the upper address bits. The physical page number and the translation-valid flag arrive in the same cycle as the virtual address, and are compared with the stored tag in that cycle to decide between hit and miss.

A lookup is combinational from the request inputs to `rd_hit` and `rd_data`. A refill controller writes a whole line, together with its physical tag, through the fill port, and the line can be seen on the next cycle. A single invalidate input empties the whole cache in one clock. The block has no sequencing state: every decision is made within the cycle, and the only registers are the arrays and the valid vector.

Top module: `vipt_cache`

## Requirements
- R1: Lookup index is `lk_vaddr[11:2]` and byte select is `lk_vaddr[1:0]`. Bits `lk_vaddr[31:12]` have no effect on the lookup result.
- R2: `rd_hit` is 1 only when `lk_req` is 1, the indexed line is valid, `lk_xlat_ok` is 1 and the stored tag equals `lk_ppn`.
- R3: When `lk_xlat_ok` is 0, `rd_hit` is 0 even if the stored tag matches `lk_ppn`.
- R4: A fill with `fl_en`=1 writes `fl_line`, the tag `fl_paddr[31:12]` and a set valid bit at index `fl_paddr[11:2]`. The new line is visible to lookups from the next cycle.
- R5: `inv_all`=1 clears every valid bit at the next edge. It wins over a fill in the same cycle, which leaves that line invalid.
- R6: After reset every line is invalid and no lookup hits.
- R7: `lk_size` selects the result: 0 = byte at the byte select, 1 = halfword at `lk_vaddr[1]` with bit 0 ignored, 2 or 3 = whole word with both select bits ignored. The line is little-endian (byte k is `line[8k+7:8k]`) and the result is zero-extended.
- R8: `rd_data` is 0 whenever `rd_hit` is 0.
- R9: A lookup in the same cycle as a fill to its index sees the contents held before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the valid bits |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_ppn | input | 20 | Translated physical page number |
| lk_xlat_ok | input | 1 | Translation produced a valid page number |
| lk_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| rd_data | output | 32 | Selected, zero-extended data on a hit |
| rd_hit | output | 1 | Lookup hit |
| fl_en | input | 1 | Line fill strobe |
| fl_paddr | input | 32 | Physical address of the filled line |
| fl_line | input | 32 | Four data bytes of the filled line |
| inv_all | input | 1 | Invalidate every line |

## Verification
The bench aims at the cases where a wrong design would return stale or foreign data as a hit. If the upper virtual bits leaked into the index, a different virtual page with the same offset would miss. If the translation-valid flag were not gated, a failed translation with a matching tag would hit. If invalidate did not win over a fill in the same cycle, that line would come back as valid. Size and offset corners (the halfword with an odd address, and size 3) would show wrong lanes or missing zero-extension. A lookup that overlaps a fill to the same index would show the new data one cycle too early.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;
endpackage

// File: rtl/vipt_valid_bits.sv
module vipt_valid_bits #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (inv_all) begin
            vld_q <= '0;
        end else if (set_en) begin
            vld_q[set_idx] <= 1'b1;
        end
    end

    assign rd_vld = vld_q[rd_idx];

    // R5: flush empties every line in one edge, fill in same cycle ignored
    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> ($countones(vld_q) == 0));

    // R4: a fill without flush marks its line valid
    p_fill_sets_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !inv_all) |=> vld_q[$past(set_idx)]);
endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_line
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_tag  = tag_mem[rd_idx];
    assign rd_line = data_mem[rd_idx];
endmodule

// File: rtl/vipt_lane_pick.sv
module vipt_lane_pick #(
    parameter int OFF_W = 2,
    parameter int SZ_W  = 2
) (
    input  logic [(8<<OFF_W)-1:0] line,
    input  logic [OFF_W-1:0]      offset,
    input  logic [SZ_W-1:0]       size,
    output logic [(8<<OFF_W)-1:0] picked
);
    localparam int DATA_W = 8 << OFF_W;

    logic [SZ_W-1:0]    eff_size;
    logic [OFF_W-1:0]   low_mask;
    logic [OFF_W-1:0]   aligned;
    logic [DATA_W-1:0]  shifted;

    always_comb begin
        eff_size = (int'(size) > OFF_W) ? SZ_W'(OFF_W) : size;
        low_mask = OFF_W'((1 << eff_size) - 1);
        aligned  = offset & ~low_mask;
        shifted  = line >> {aligned, 3'b000};
        picked   = '0;
        for (int s = 0; s <= OFF_W; s++) begin
            if (int'(eff_size) == s) begin
                for (int b = 0; b < DATA_W; b++) begin
                    if (b < (8 << s)) picked[b] = shifted[b];
                end
            end
        end
    end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int VA_W       = 32,
    parameter int PPN_W      = 20,
    parameter int IDX_W      = 10,
    parameter int LINE_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_req,
    input  logic [VA_W-1:0]          lk_vaddr,
    input  logic [PPN_W-1:0]         lk_ppn,
    input  logic                     lk_xlat_ok,
    input  logic [1:0]               lk_size,
    output logic [8*LINE_BYTES-1:0]  rd_data,
    output logic                     rd_hit,
    input  logic                     fl_en,
    input  logic [VA_W-1:0]          fl_paddr,
    input  logic [8*LINE_BYTES-1:0]  fl_line,
    input  logic                     inv_all
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int DATA_W = 8 * LINE_BYTES;
    localparam int PG_W   = IDX_W + OFF_W;

    logic [IDX_W-1:0]  lk_idx, fl_idx;
    logic [OFF_W-1:0]  lk_off;
    logic [PPN_W-1:0]  fl_tag, st_tag;
    logic [DATA_W-1:0] st_line, picked;
    logic              st_vld, tag_eq;

    // index and byte select come only from the page offset
    assign lk_off = lk_vaddr[OFF_W-1:0];
    assign lk_idx = lk_vaddr[PG_W-1:OFF_W];
    assign fl_idx = fl_paddr[PG_W-1:OFF_W];
    assign fl_tag = fl_paddr[PG_W+PPN_W-1:PG_W];

    vipt_valid_bits #(.IDX_W(IDX_W)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv_all (inv_all),
        .set_en  (fl_en),
        .set_idx (fl_idx),
        .rd_idx  (lk_idx),
        .rd_vld  (st_vld)
    );

    vipt_line_store #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (fl_en),
        .wr_idx  (fl_idx),
        .wr_tag  (fl_tag),
        .wr_line (fl_line),
        .rd_idx  (lk_idx),
        .rd_tag  (st_tag),
        .rd_line (st_line)
    );

    vipt_lane_pick #(.OFF_W(OFF_W), .SZ_W(2)) u_pick (
        .line   (st_line),
        .offset (lk_off),
        .size   (lk_size),
        .picked (picked)
    );

    // the tag compare runs beside the array read
    assign tag_eq  = (st_tag == lk_ppn);
    assign rd_hit  = lk_req && lk_xlat_ok && st_vld && tag_eq;
    assign rd_data = rd_hit ? picked : '0;

    // R3: no hit without a valid translation
    p_xlat_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_xlat_ok |-> !rd_hit);

    // R8: data is quiet on a miss
    p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data == '0));

    // R7: a byte access is zero-extended
    p_byte_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_size == 2'd0) |-> (rd_data[DATA_W-1:8] == '0));

    // R5: right after a flush nothing hits
    p_flush_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !rd_hit);

    // R2: a hit needs a request
    p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> lk_req);
endmodule

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb;
    import vipt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [19:0] lk_ppn = '0;
    logic        lk_xlat_ok = 1'b0;
    logic [1:0]  lk_size = 2'd0;
    logic [31:0] rd_data;
    logic        rd_hit;
    logic        fl_en = 1'b0;
    logic [31:0] fl_paddr = '0;
    logic [31:0] fl_line = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          m_vld [1024];
    logic [19:0] m_tag [1024];
    logic [31:0] m_dat [1024];

    always #2 clk = ~clk;

    vipt_cache u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_ppn(lk_ppn), .lk_xlat_ok(lk_xlat_ok), .lk_size(lk_size),
        .rd_data(rd_data), .rd_hit(rd_hit), .fl_en(fl_en),
        .fl_paddr(fl_paddr), .fl_line(fl_line), .inv_all(inv_all)
    );

    function automatic logic [31:0] pick(logic [31:0] ln, logic [1:0] off, logic [1:0] sz);
        case (sz)
            2'd0:    return {24'd0, ln[off*8 +: 8]};
            2'd1:    return {16'd0, ln[off[1]*16 +: 16]};
            default: return ln;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive inputs at the falling edge, check mid-cycle, then commit at the rising edge
    task automatic step(string req, bit rq, logic [31:0] va, logic [19:0] ppn, bit xok,
                        logic [1:0] sz, bit fe, logic [31:0] fpa, logic [31:0] fln, bit inv);
        bit eh;
        logic [31:0] ed;
        int ix;
        @(negedge clk);
        lk_req = rq; lk_vaddr = va; lk_ppn = ppn; lk_xlat_ok = xok; lk_size = sz;
        fl_en = fe; fl_paddr = fpa; fl_line = fln; inv_all = inv;
        #1;
        ix = int'(va[11:2]);
        eh = rq && xok && m_vld[ix] && (m_tag[ix] == ppn);
        ed = eh ? pick(m_dat[ix], va[1:0], sz) : 32'd0;
        chk({req, " hit"}, {31'd0, rd_hit}, {31'd0, eh});
        chk({req, " data"}, rd_data, ed);
        @(posedge clk);
        if (inv) begin
            for (int i = 0; i < 1024; i++) m_vld[i] = 1'b0;
        end
        if (fe) begin
            m_tag[fpa[11:2]] = fpa[31:12];
            m_dat[fpa[11:2]] = fln;
            if (!inv) m_vld[fpa[11:2]] = 1'b1;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < 1024; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_dat[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: after reset nothing hits, even with zero tag
        step("R6", 1, 32'h0000_0000, 20'h0, 1, SZ_WORD, 0, 0, 0, 0);
        step("R6", 1, 32'h0000_0ffc, 20'h0, 1, SZ_WORD, 0, 0, 0, 0);

        // R4: fill, then hit from next cycle
        step("R4", 0, 0, 0, 0, SZ_WORD, 1, 32'hABCDE_010, 32'h8877_6655, 0);
        step("R4", 1, 32'h1234_5010, 20'hABCDE, 1, SZ_WORD, 0, 0, 0, 0);
        // R1: another virtual page, same offset, still hits
        step("R1", 1, 32'hFFFF_F010, 20'hABCDE, 1, SZ_WORD, 0, 0, 0, 0);
        // R2: tag mismatch misses; no request misses
        step("R2", 1, 32'h1234_5010, 20'hABCDF, 1, SZ_WORD, 0, 0, 0, 0);
        step("R2", 0, 32'h1234_5010, 20'hABCDE, 1, SZ_WORD, 0, 0, 0, 0);
        // R3: translation miss with matching tag
        step("R3", 1, 32'h1234_5010, 20'hABCDE, 0, SZ_WORD, 0, 0, 0, 0);
        // R7: sizes and offsets
        step("R7", 1, 32'h0000_0013, 20'hABCDE, 1, SZ_BYTE, 0, 0, 0, 0);
        step("R7", 1, 32'h0000_0011, 20'hABCDE, 1, SZ_BYTE, 0, 0, 0, 0);
        step("R7", 1, 32'h0000_0013, 20'hABCDE, 1, SZ_HALF, 0, 0, 0, 0);
        step("R7", 1, 32'h0000_0011, 20'hABCDE, 1, SZ_HALF, 0, 0, 0, 0);
        step("R7", 1, 32'h0000_0013, 20'hABCDE, 1, SZ_WIDE, 0, 0, 0, 0);
        // R9: lookup during fill of same index sees old line
        step("R9", 1, 32'h0000_0010, 20'hABCDE, 1, SZ_WORD, 1, 32'h11111_010, 32'hDEAD_BEEF, 0);
        step("R9", 1, 32'h0000_0010, 20'h11111, 1, SZ_WORD, 0, 0, 0, 0);
        // R5: flush with simultaneous fill leaves everything invalid
        step("R5", 0, 0, 0, 0, SZ_WORD, 1, 32'h22222_020, 32'h0102_0304, 0);
        step("R5", 1, 32'h0000_0020, 20'h22222, 1, SZ_WORD, 1, 32'h33333_030, 32'h0506_0708, 1);
        step("R5", 1, 32'h0000_0020, 20'h22222, 1, SZ_WORD, 0, 0, 0, 0);
        step("R5", 1, 32'h0000_0030, 20'h33333, 1, SZ_WORD, 0, 0, 0, 0);
        // R8 and R2 under random traffic on a narrow set of indices and tags
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] va, fa;
            logic [19:0] pp;
            bit fe, iv;
            va = {$urandom, 0} ;
            va[11:2] = 10'($urandom_range(0, 7));
            pp = 20'($urandom_range(0, 3));
            fa = {20'($urandom_range(0, 3)), 10'($urandom_range(0, 7)), 2'b00};
            fe = ($urandom_range(0, 3) == 0);
            iv = ($urandom_range(0, 99) == 0);
            step("R8", $urandom_range(0, 7) != 0, va, pp, $urandom_range(0, 5) != 0,
                 2'($urandom), fe, fa, $urandom, iv);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule